// File: doc/BRIEF.md
# Grouped Event Interrupt Controller

This block turns eighteen asynchronous event lines into three primary interrupt requests. One line carries a thermal warning level, one carries a power-button level and sixteen carry general-purpose I/O events. Every line is first brought into the clock domain, then passed through a trigger detector. The detector's hit latches a secondary status bit. Each status bit has a mask bit beside it, and each group of unmasked status bits drives one primary output.

Software reaches the status, mask and trigger-mode registers over a simple single-cycle register bus. A write has effect at the clock edge on which `bus_we` is high. A read is combinational from `bus_addr`. Status bits are cleared by writing ones to them. A status bit records its event even when the event is masked, so a read of the status register always shows what has occurred.

Top module: `irq_hub`

## Requirements
- R1: A primary output is high only when at least one status bit in its group is set with its mask bit at 0. A mask bit of 1 keeps that status bit from raising the output.
- R2: After reset every mask bit is 1, every status bit is 0, every GPIO mode field is 00 and all three primary outputs are low.
- R3: A triggered event sets its status bit whether its mask bit is 0 or 1.
- R4: On a bus write to a status address, each data bit of 1 clears the matching status bit. Each data bit of 0 leaves its status bit unchanged.
- R5: `evt_in[0]` (thermal warning) and `evt_in[1]` (power button) set their status bits on both rising and falling edges.
- R6: `evt_in[2+n]` is GPIO n. Its 2-bit mode selects the trigger: 00 rising edge, 01 falling edge, 10 both edges, 11 high level. In level mode the status bit sets again on the cycle after a clear while the input stays high.
- R7: An event that triggers in the same cycle as a write-one-to-clear of its bit wins, and the bit stays set.
- R8: Register map, 16-bit data. Address 0 is the system status: bit 1 is thermal, bit 12 is button, and all other bits read 0. Address 1 is the system mask, using the same bit positions. Address 2 is the GPIO status, with GPIO n at bit n. Address 3 is the GPIO mask. Address 4 holds the modes of GPIOs 0 to 7, and address 5 holds GPIOs 8 to 15; GPIO n uses bits 2(n mod 8)+1 down to 2(n mod 8). Addresses 6 and 7 read 0.
- R9: An input change set up before a clock edge shows up in the status read after the third edge, and not after the second. The primary output follows one edge later and stays high until the group has no unmasked set bit.
- R10: Inputs held high through reset produce no event once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 18 | Event lines: 0 thermal, 1 button, 2..17 GPIO 0..15 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_therm | output | 1 | Thermal primary interrupt |
| irq_button | output | 1 | Power-button primary interrupt |
| irq_gpio | output | 1 | GPIO primary interrupt |

## Verification
The bench changes event inputs on a falling edge. Two synchronizer stages and the status register then place a status result after the third rising edge that follows. The bench reads the status on the falling edge after that third edge, and for R9 it also confirms the bit is still clear after the second edge. The primary outputs are registered from status and mask, so the bench samples them one further edge later, and likewise one edge after any mask or clear write. For the collision case the clearing write is timed to land on exactly that third edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned GPIO_N  = 16;
  localparam int unsigned EVT_W   = GPIO_N + 2;
  localparam int unsigned THERM_BIT  = 1;
  localparam int unsigned BUTTON_BIT = 12;

  localparam logic [ADDR_W-1:0] A_SYS_ST   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SYS_MSK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_GPIO_ST  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GPIO_MSK = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE_HI  = 3'd5;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_BOTH  = 2'b10,
    TRIG_LEVEL = 2'b11
  } trig_mode_e;

  function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prev);
    case (mode)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return cur;
    endcase
  endfunction

  function automatic logic group_pending(logic [DATA_W-1:0] st, logic [DATA_W-1:0] msk);
    return |(st & ~msk);
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W      = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic         armed_o
);
  localparam int unsigned ARM_W = STAGES + 1;

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;
  logic [ARM_W-1:0] arm_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= lvl_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= stage_q[STAGES-1];
      arm_q  <= {arm_q[ARM_W-2:0], 1'b1};
    end
  end

  assign cur_o   = stage_q[STAGES-1];
  assign prev_o  = prev_q;
  assign armed_o = arm_q[ARM_W-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_hub_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we,
  input  logic [W-1:0] mask_d,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, mask_q;
  logic         irq_q;
  logic [DATA_W-1:0] st_ext, msk_ext;

  assign st_ext  = DATA_W'(status_q);
  assign msk_ext = {{(DATA_W-W){1'b1}}, mask_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (mask_we) mask_q <= mask_d;
      irq_q    <= group_pending(st_ext, msk_ext);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_therm,
  output logic              irq_button,
  output logic              irq_gpio
);
  localparam int unsigned MODE_W = 2 * GPIO_N;

  logic [EVT_W-1:0]  cur, prev;
  logic              armed;
  logic [MODE_W-1:0] mode_q;
  logic              therm_set, button_set;
  logic [GPIO_N-1:0] gpio_set;
  logic              therm_st, therm_mask, button_st, button_mask;
  logic [GPIO_N-1:0] gpio_st, gpio_mask;
  logic              wr_sys_st, wr_sys_msk, wr_gpio_st, wr_gpio_msk;

  irq_edge_sync #(.W(EVT_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_in),
    .cur_o(cur), .prev_o(prev), .armed_o(armed)
  );

  assign therm_set  = armed & trig_hit(TRIG_BOTH, cur[0], prev[0]);
  assign button_set = armed & trig_hit(TRIG_BOTH, cur[1], prev[1]);

  for (genvar g = 0; g < GPIO_N; g++) begin : g_trig
    assign gpio_set[g] = armed & trig_hit(trig_mode_e'(mode_q[2*g +: 2]), cur[g+2], prev[g+2]);
  end

  assign wr_sys_st   = bus_we && (bus_addr == A_SYS_ST);
  assign wr_sys_msk  = bus_we && (bus_addr == A_SYS_MSK);
  assign wr_gpio_st  = bus_we && (bus_addr == A_GPIO_ST);
  assign wr_gpio_msk = bus_we && (bus_addr == A_GPIO_MSK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (bus_we && bus_addr == A_MODE_LO) mode_q[DATA_W-1:0]      <= bus_wdata;
    else if (bus_we && bus_addr == A_MODE_HI) mode_q[MODE_W-1:DATA_W] <= bus_wdata;
  end

  irq_status_bank #(.W(1)) u_therm (
    .clk(clk), .rst_n(rst_n), .set_i(therm_set),
    .clr_i(wr_sys_st & bus_wdata[THERM_BIT]),
    .mask_we(wr_sys_msk), .mask_d(bus_wdata[THERM_BIT]),
    .status_o(therm_st), .mask_o(therm_mask), .irq_o(irq_therm)
  );

  irq_status_bank #(.W(1)) u_button (
    .clk(clk), .rst_n(rst_n), .set_i(button_set),
    .clr_i(wr_sys_st & bus_wdata[BUTTON_BIT]),
    .mask_we(wr_sys_msk), .mask_d(bus_wdata[BUTTON_BIT]),
    .status_o(button_st), .mask_o(button_mask), .irq_o(irq_button)
  );

  irq_status_bank #(.W(GPIO_N)) u_gpio (
    .clk(clk), .rst_n(rst_n), .set_i(gpio_set),
    .clr_i(wr_gpio_st ? bus_wdata : '0),
    .mask_we(wr_gpio_msk), .mask_d(bus_wdata),
    .status_o(gpio_st), .mask_o(gpio_mask), .irq_o(irq_gpio)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SYS_ST: begin
        bus_rdata[THERM_BIT]  = therm_st;
        bus_rdata[BUTTON_BIT] = button_st;
      end
      A_SYS_MSK: begin
        bus_rdata[THERM_BIT]  = therm_mask;
        bus_rdata[BUTTON_BIT] = button_mask;
      end
      A_GPIO_ST:  bus_rdata = gpio_st;
      A_GPIO_MSK: bus_rdata = gpio_mask;
      A_MODE_LO:  bus_rdata = mode_q[DATA_W-1:0];
      A_MODE_HI:  bus_rdata = mode_q[MODE_W-1:DATA_W];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [GPIO_N-1:0] gpio_set,
  input logic [GPIO_N-1:0] gpio_st,
  input logic [GPIO_N-1:0] gpio_mask,
  input logic              therm_set,
  input logic              therm_st,
  input logic              irq_gpio
);
  logic mask_touched;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_touched <= 1'b0;
    else if (bus_we && bus_addr == A_GPIO_MSK) mask_touched <= 1'b1;

  p_mask_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_touched |-> gpio_mask == '1);

  p_latch_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_set) |=> (gpio_st & $past(gpio_set)) == $past(gpio_set));

  p_therm_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    therm_set |=> therm_st);

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_GPIO_ST && (bus_wdata & ~gpio_set) != '0)
      |=> (gpio_st & $past(bus_wdata & ~gpio_set)) == '0);

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_GPIO_ST && bus_wdata == '0)
      |=> (gpio_st & $past(gpio_st)) == $past(gpio_st));

  p_irq_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_st & ~gpio_mask) == '0 |=> !irq_gpio);

  p_irq_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_st & ~gpio_mask) != '0 |=> irq_gpio);
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .gpio_set(gpio_set), .gpio_st(gpio_st),
  .gpio_mask(gpio_mask), .therm_set(therm_set), .therm_st(therm_st),
  .irq_gpio(irq_gpio)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] evt_in = '1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq_therm, irq_button, irq_gpio;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_therm(irq_therm), .irq_button(irq_button), .irq_gpio(irq_gpio)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    step(2); rst_n = 1'b1; step(6);
    rd_chk("R10 sys status quiet", 3'd0, 16'h0000);
    rd_chk("R10 gpio status quiet", 3'd2, 16'h0000);
    rd_chk("R2 sys mask", 3'd1, 16'h1002);
    rd_chk("R2 gpio mask", 3'd3, 16'hFFFF);
    rd_chk("R2 mode lo", 3'd4, 16'h0000);
    chk("R2 irqs low", {13'd0, irq_therm, irq_button, irq_gpio}, 16'h0);
  endtask

  task automatic t_sys_falls;
    evt_in = '0; step(3);
    rd_chk("R5 falls latched masked R3", 3'd0, 16'h1002);
    rd_chk("R6 rise mode ignores fall", 3'd2, 16'h0000);
    step(1);
    chk("R1 masked therm irq", {15'd0, irq_therm}, 16'h0);
    wr(3'd1, 16'h1000); step(1);
    chk("R1 unmasked therm irq", {15'd0, irq_therm}, 16'h1);
    chk("R1 button still masked", {15'd0, irq_button}, 16'h0);
    wr(3'd0, 16'h0002);
    rd_chk("R4 clear thermal only", 3'd0, 16'h1000);
    step(1);
    chk("R9 irq drops after clear", {15'd0, irq_therm}, 16'h0);
    wr(3'd0, 16'h0000);
    rd_chk("R4 zero write keeps", 3'd0, 16'h1000);
    wr(3'd0, 16'h1000);
    rd_chk("R4 clear button", 3'd0, 16'h0000);
  endtask

  task automatic t_therm_rise;
    evt_in[0] = 1'b1; step(1); @(posedge clk); @(negedge clk);
    rd_chk("R9 not yet after two edges", 3'd0, 16'h0000);
    step(1);
    rd_chk("R9 R5 rise after three edges", 3'd0, 16'h0002);
    step(1);
    chk("R9 irq one edge later", {15'd0, irq_therm}, 16'h1);
    step(3);
    chk("R9 irq holds", {15'd0, irq_therm}, 16'h1);
    wr(3'd0, 16'h0002);
  endtask

  task automatic t_gpio_modes;
    wr(3'd4, 16'h00E4);
    rd_chk("R8 mode lo readback", 3'd4, 16'h00E4);
    wr(3'd3, 16'hFFF0);
    evt_in[5:2] = 4'hF; step(3);
    rd_chk("R6 rise/both/level on high", 3'd2, 16'h000D);
    step(1);
    chk("R1 gpio irq", {15'd0, irq_gpio}, 16'h1);
    wr(3'd2, 16'h000F);
    rd_chk("R6 level sets again", 3'd2, 16'h0008);
    evt_in[5:2] = 4'h0; step(3);
    rd_chk("R6 fall/both on low", 3'd2, 16'h000E);
    wr(3'd2, 16'hFFFF);
    rd_chk("R4 all cleared", 3'd2, 16'h0000);
    step(1);
    chk("R1 gpio irq off", {15'd0, irq_gpio}, 16'h0);
  endtask

  task automatic t_collision;
    evt_in[4] = 1'b1; step(3);
    rd_chk("R6 both mode rise", 3'd2, 16'h0004);
    evt_in[4] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 16'h0004; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd_chk("R7 event beats clear", 3'd2, 16'h0004);
    wr(3'd2, 16'h0004);
    rd_chk("R7 later clear works", 3'd2, 16'h0000);
  endtask

  task automatic t_masked_gpio;
    evt_in[10] = 1'b1; step(3);
    rd_chk("R3 masked gpio8 latches", 3'd2, 16'h0100);
    step(1);
    chk("R1 masked gpio8 no irq", {15'd0, irq_gpio}, 16'h0);
    wr(3'd3, 16'hFEF0); step(1);
    chk("R1 unmask gpio8 irq", {15'd0, irq_gpio}, 16'h1);
    wr(3'd2, 16'h0100); evt_in[10] = 1'b0; step(1);
    chk("R1 irq after clear", {15'd0, irq_gpio}, 16'h0);
  endtask

  task automatic t_map;
    wr(3'd5, 16'hA5C3);
    rd_chk("R8 mode hi readback", 3'd5, 16'hA5C3);
    rd_chk("R8 addr 6 zero", 3'd6, 16'h0000);
    rd_chk("R8 addr 7 zero", 3'd7, 16'h0000);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_sys_falls();
    t_therm_rise();
    t_gpio_modes();
    t_collision();
    t_masked_gpio();
    t_map();
    finish_run();
  end
endmodule